// File: doc/BRIEF.md
# NOR Flash Byte Program Sequencer with Completion Polling

This block sits on the host side of a parallel NOR flash. It writes a run of bytes into consecutive flash locations. For each byte it sends the three-cycle unlock and program command on the flash bus, then the data byte at the target address. It then reads the target location until the flash reports that the embedded program operation has ended. When the byte succeeds it advances to the next address and asks the data source for the next byte. When the run ends it raises `done`.

Completion is found by one of two methods, chosen per run by `use_toggle`. The first compares the returned bit 7 with bit 7 of the written byte. The second watches bit 6 toggle between two consecutive reads. The flash's timeout indication (bit 5) never causes failure on its own: the status is always read again first, because the flash may finish in the same instant. On failure the block writes the reset command, raises `fail` with the failing address, and stops. A poll budget, set per run, also ends a byte that shows neither completion nor timeout.

Bus timing is abstracted. Every access takes `BUS_CLKS` clocks. The strobe (`bus_we` or `bus_re`) is high for the first `BUS_CLKS-1` clocks and low for the last. Address and write data are held for the whole access.

Top module: `nor_prog_poller`

## Requirements
- R1: While reset is asserted and after it is released with no start, `busy`, `done`, `fail`, `bus_we`, `bus_re` and `src_take` are all 0.
- R2: Each byte is written as four write accesses in this order: 0xAA at address 0x555, 0x55 at address 0x2AA, 0xA0 at address 0x555, then the data byte at the target address (upper address bits zero for the command addresses).
- R3: With `use_toggle`=0, the block reads the target address once per poll and ends the byte on the first read whose bit 7 equals bit 7 of the written byte, with no further reads of that byte.
- R4: With `use_toggle`=0, a read whose bit 7 mismatches and whose bit 5 is 1 causes exactly one more read. If bit 7 then matches, the byte succeeds, whatever the poll budget; otherwise the run fails.
- R5: With `use_toggle`=1, the block reads the target address in pairs and ends the byte when bit 6 is equal in both reads of a pair.
- R6: With `use_toggle`=1, a pair whose bit 6 differs and whose second read has bit 5 = 1 causes exactly one more pair. If bit 6 is then equal, the byte succeeds, whatever the poll budget; otherwise the run fails.
- R7: After each successful byte the target address increments by one. `src_take` pulses once per byte, just before its command sequence. After `byte_count` bytes, `busy` falls and `done` is 1 with `fail` 0.
- R8: On failure the block issues one write of 0xF0 at the failing address, then drops `busy`, sets `fail` to 1, `done` to 0 and `fail_addr` to the failing address, and programs no further bytes.
- R9: A byte with no completion and no bit 5 fails as in R8 after max(`poll_limit`,1) polls (single reads with `use_toggle`=0, read pairs with `use_toggle`=1).
- R10: Every access keeps its strobe high for exactly `BUS_CLKS-1` consecutive clocks, and `bus_we` and `bus_re` are never high together.
- R11: `start` is ignored while `busy` is 1. An accepted `start` clears `done` and `fail`. A `byte_count` of 0 sets `done` with no bus access and no `src_take`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run (taken only when idle) |
| start_addr | input | ADDR_W | First target address |
| byte_count | input | CNT_W | Number of bytes in the run |
| use_toggle | input | 1 | 0: bit 7 compare polling, 1: bit 6 toggle polling |
| poll_limit | input | WDOG_W | Poll budget per byte without completion or timeout |
| src_data | input | 8 | Next byte from the data source |
| src_take | output | 1 | One-cycle pulse: `src_data` is consumed |
| bus_addr | output | ADDR_W | Flash bus address |
| bus_wdata | output | 8 | Flash bus write data |
| bus_we | output | 1 | Write strobe |
| bus_re | output | 1 | Read strobe |
| bus_rdata | input | 8 | Flash bus read data |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run completed successfully |
| fail | output | 1 | Last run stopped on a failed byte |
| fail_addr | output | ADDR_W | Address of the byte that failed |

## Verification
The bench targets the timeout bit appearing on the same read as the final status. It pairs this with a poll budget of one, so a design that fails on the first bit 5 sighting, or that skips the confirming re-read, reports `fail` where `done` is expected. Timeouts that persist must produce exactly one extra read or read pair and then the 0xF0 write. A design that re-reads too often, or never gives up, shows a wrong read count or a missing reset write in the scoreboard. The bench also checks the budget at zero and at small values, a failure in the middle of a run that must not consume further data bytes, and a second start during a run that must leave the write stream untouched.

// File: rtl/nor_prog_poller.sv
module nor_prog_poller #(
  parameter int ADDR_W   = 18,
  parameter int CNT_W    = 18,
  parameter int WDOG_W   = 16,
  parameter int BUS_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic              use_toggle,
  input  logic [WDOG_W-1:0] poll_limit,
  input  logic [7:0]        src_data,
  output logic              src_take,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  output logic              bus_we,
  output logic              bus_re,
  input  logic [7:0]        bus_rdata,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr
);

  localparam int AC_W = (BUS_CLKS > 2) ? $clog2(BUS_CLKS) : 1;
  localparam logic [AC_W-1:0] AC_LAST = AC_W'(BUS_CLKS - 1);
  localparam logic [AC_W-1:0] AC_SAMP = AC_W'(BUS_CLKS - 2);
  localparam logic [ADDR_W-1:0] UNLK_A = ADDR_W'(12'h555);
  localparam logic [ADDR_W-1:0] UNLK_B = ADDR_W'(12'h2AA);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_CMD, S_POLL, S_ABORT} st_t;

  st_t               st;
  logic [AC_W-1:0]   ac;
  logic [1:0]        step;
  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0]  remain;
  logic [7:0]        wdat;
  logic [2:0]        rq;
  logic              first_b6;
  logic [WDOG_W-1:0] pcnt;
  logic [WDOG_W-1:0] limit_r;
  logic              tg_r;
  logic              rd_odd;
  logic              retry;

  wire accessing = (st == S_CMD) || (st == S_POLL) || (st == S_ABORT);
  wire acc_end   = (ac == AC_LAST);
  wire strobe    = accessing && !acc_end;
  wire cmp_hit   = tg_r ? (first_b6 == rq[1]) : (rq[2] == wdat[7]);
  wire wd_hit    = ((WDOG_W+1)'(pcnt) + 1'b1) >= (WDOG_W+1)'(limit_r);

  assign busy     = (st != S_IDLE);
  assign src_take = (st == S_LOAD);
  assign bus_we   = strobe && (st != S_POLL);
  assign bus_re   = strobe && (st == S_POLL);

  always_comb begin
    bus_addr  = addr;
    bus_wdata = 8'hF0;
    if (st == S_CMD) begin
      case (step)
        2'd0: begin bus_addr = UNLK_A; bus_wdata = 8'hAA; end
        2'd1: begin bus_addr = UNLK_B; bus_wdata = 8'h55; end
        2'd2: begin bus_addr = UNLK_A; bus_wdata = 8'hA0; end
        default: bus_wdata = wdat;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ac        <= '0;
      step      <= '0;
      addr      <= '0;
      remain    <= '0;
      wdat      <= '0;
      rq        <= '0;
      first_b6  <= 1'b0;
      pcnt      <= '0;
      limit_r   <= '0;
      tg_r      <= 1'b0;
      rd_odd    <= 1'b0;
      retry     <= 1'b0;
      done      <= 1'b0;
      fail      <= 1'b0;
      fail_addr <= '0;
    end else begin
      ac <= (accessing && !acc_end) ? ac + 1'b1 : '0;
      if (bus_re && ac == AC_SAMP) rq <= bus_rdata[7:5];
      case (st)
        S_IDLE: if (start) begin
          done    <= (byte_count == '0);
          fail    <= 1'b0;
          addr    <= start_addr;
          remain  <= byte_count;
          tg_r    <= use_toggle;
          limit_r <= poll_limit;
          if (byte_count != '0) st <= S_LOAD;
        end
        S_LOAD: begin
          wdat   <= src_data;
          step   <= '0;
          pcnt   <= '0;
          retry  <= 1'b0;
          rd_odd <= 1'b0;
          st     <= S_CMD;
        end
        S_CMD: if (acc_end) begin
          if (step == 2'd3) st <= S_POLL;
          else step <= step + 1'b1;
        end
        S_POLL: if (acc_end) begin
          if (tg_r && !rd_odd) begin
            first_b6 <= rq[1];
            rd_odd   <= 1'b1;
          end else begin
            rd_odd <= 1'b0;
            if (cmp_hit) begin
              if (remain == CNT_W'(1)) begin
                done <= 1'b1;
                st   <= S_IDLE;
              end else begin
                addr   <= addr + 1'b1;
                remain <= remain - 1'b1;
                st     <= S_LOAD;
              end
            end else if (retry) begin
              st <= S_ABORT;
            end else if (rq[0]) begin
              retry <= 1'b1;
            end else if (wd_hit) begin
              st <= S_ABORT;
            end else begin
              pcnt <= pcnt + 1'b1;
            end
          end
        end
        S_ABORT: if (acc_end) begin
          fail      <= 1'b1;
          fail_addr <= addr;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nor_prog_poller_chk.sv
module nor_prog_poller_chk #(
  parameter int BUS_CLKS = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_we,
  input logic       bus_re,
  input logic       src_take,
  input logic       busy,
  input logic       done,
  input logic       fail,
  input logic [7:0] bus_wdata
);

  int         run;
  logic [7:0] last_wd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 0;
      last_wd <= 8'h00;
    end else begin
      run <= (bus_we || bus_re) ? run + 1 : 0;
      if (bus_we) last_wd <= bus_wdata;
    end
  end

  // R10
  we_re_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re));

  // R10
  strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we || bus_re) |-> (run < BUS_CLKS - 1));

  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  // R8
  abort_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> (last_wd == 8'hF0));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(bus_we || bus_re || src_take));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !busy);

endmodule

bind nor_prog_poller nor_prog_poller_chk #(.BUS_CLKS(BUS_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
  .src_take(src_take), .busy(busy), .done(done), .fail(fail),
  .bus_wdata(bus_wdata)
);

// File: tb/nor_prog_poller_tb.sv
`timescale 1ns/1ps
module nor_prog_poller_tb;

  localparam int ADDR_W = 18, CNT_W = 18, WDOG_W = 16, BUS_CLKS = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, use_toggle = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic [CNT_W-1:0]  byte_count = '0;
  logic [WDOG_W-1:0] poll_limit = '0;
  logic [7:0]        src_data, bus_wdata, bus_rdata;
  logic [ADDR_W-1:0] bus_addr, fail_addr;
  logic src_take, bus_we, bus_re, busy, done, fail;

  always #4 clk = ~clk;

  nor_prog_poller #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WDOG_W(WDOG_W), .BUS_CLKS(BUS_CLKS)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_count(byte_count), .use_toggle(use_toggle), .poll_limit(poll_limit),
    .src_data(src_data), .src_take(src_take), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr));

  int nchk = 0, nbad = 0;
  logic [ADDR_W+7:0] exp_q[$];

  logic [7:0] src_arr[0:7];
  int sidx = 0, takes = 0;
  assign src_data = src_arr[sidx];
  always @(posedge clk) if (src_take) begin sidx <= sidx + 1; takes <= takes + 1; end

  // flash model
  logic [7:0] mem[0:255];
  logic busy_f = 1'b0, tog = 1'b0, st5;
  logic [7:0] pd = '0;
  logic [ADDR_W-1:0] paddr = '0;
  int nrd = 0, u = 0, cur_lat = 2, cur_t5 = 0, prog_num = 0;
  int sp_idx = -1, sp_lat = 2, sp_t5 = 0;
  int reads = 0, rd_bad = 0, wid = 0, wid_bad = 0, wid_seen = 0;

  assign st5 = (cur_t5 != 0) && (nrd + 1 >= cur_t5);
  assign bus_rdata = busy_f ? {~pd[7], tog, st5, 5'b0} : mem[bus_addr[7:0]];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor + model write side
  always @(negedge bus_we) begin
    logic [ADDR_W+7:0] e;
    nchk++;
    if (exp_q.size() == 0) begin
      nbad++;
      $display("FAIL R2 unexpected write: actual %h/%h expected none", bus_addr, bus_wdata);
    end else begin
      e = exp_q.pop_front();
      if ({bus_addr, bus_wdata} != e) begin
        nbad++;
        $display("FAIL %s write: actual %h/%h expected %h/%h", (e[7:0] == 8'hF0) ? "R8" : "R2",
                 bus_addr, bus_wdata, e[ADDR_W+7:8], e[7:0]);
      end
    end
    if (bus_wdata == 8'hF0) begin busy_f = 1'b0; u = 0; end
    else case (u)
      0: u = (bus_addr == 18'h555 && bus_wdata == 8'hAA) ? 1 : 0;
      1: u = (bus_addr == 18'h2AA && bus_wdata == 8'h55) ? 2 : 0;
      2: u = (bus_addr == 18'h555 && bus_wdata == 8'hA0) ? 3 : 0;
      default: begin
        busy_f = 1'b1; nrd = 0; tog = 1'b0; pd = bus_wdata; paddr = bus_addr;
        cur_lat = (prog_num == sp_idx) ? sp_lat : 2;
        cur_t5  = (prog_num == sp_idx) ? sp_t5 : 0;
        prog_num++; u = 0;
      end
    endcase
  end

  always @(negedge bus_re) begin
    reads++;
    if (bus_addr != paddr) rd_bad++;
    if (busy_f) begin
      nrd++; tog = ~tog;
      if (nrd >= cur_lat) begin busy_f = 1'b0; mem[paddr[7:0]] = pd; end
    end
  end

  always @(posedge clk) begin
    if (bus_we || bus_re) wid <= wid + 1;
    else if (wid != 0) begin
      wid_seen <= wid_seen + 1;
      if (wid != BUS_CLKS - 1) wid_bad <= wid_bad + 1;
      wid <= 0;
    end
  end

  task automatic expect_prog(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    exp_q.push_back({18'h555, 8'hAA});
    exp_q.push_back({18'h2AA, 8'h55});
    exp_q.push_back({18'h555, 8'hA0});
    exp_q.push_back({a, d});
  endtask

  task automatic kick(input logic [ADDR_W-1:0] a, input int n, input bit tg, input int lim);
    @(negedge clk);
    start_addr = a; byte_count = CNT_W'(n); use_toggle = tg; poll_limit = WDOG_W'(lim);
    reads = 0; takes = 0; sidx = 0; prog_num = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_wait();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic knobs(input int idx, input int lat, input int t5);
    sp_idx = idx; sp_lat = lat; sp_t5 = t5;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    src_arr[0] = 8'h5A; src_arr[1] = 8'hC3; src_arr[2] = 8'h0F; src_arr[3] = 8'h81;
    src_arr[4] = 8'h66; src_arr[5] = 8'h99; src_arr[6] = 8'h24; src_arr[7] = 8'hE7;
    repeat (3) @(negedge clk);
    // R1
    chk({busy, done, fail, bus_we, bus_re, src_take} == 6'b0, "R1", "outputs in reset", {busy, done, fail, bus_we, bus_re, src_take}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({busy, done, fail, bus_we, bus_re, src_take} == 6'b0, "R1", "outputs after reset", {busy, done, fail, bus_we, bus_re, src_take}, 0);

    // R3 R7: bit 7 polling, four bytes
    knobs(-1, 2, 0);
    for (int i = 0; i < 4; i++) expect_prog(18'h010 + 18'(i), src_arr[i]);
    kick(18'h010, 4, 1'b0, 20); finish_wait();
    chk(done && !fail, "R7", "done after run", {done, fail}, 2);
    chk(takes == 4, "R7", "src_take count", takes, 4);
    chk(reads == 12, "R3", "reads for 4 bytes", reads, 12);
    chk(mem[8'h13] == 8'h81 && mem[8'h10] == 8'h5A, "R7", "bytes programmed", {mem[8'h10], mem[8'h13]}, 16'h5A81);
    chk(exp_q.size() == 0, "R2", "pending writes", exp_q.size(), 0);

    // R5: toggle polling, three bytes
    for (int i = 0; i < 3; i++) expect_prog(18'h020 + 18'(i), src_arr[i]);
    kick(18'h020, 3, 1'b1, 20); finish_wait();
    chk(done && !fail, "R5", "toggle run done", {done, fail}, 2);
    chk(reads == 12, "R5", "reads in pairs", reads, 12);
    chk(exp_q.size() == 0, "R2", "pending writes", exp_q.size(), 0);

    // R4: bit 5 on the final status read, budget of one
    knobs(0, 1, 1);
    expect_prog(18'h030, src_arr[0]);
    kick(18'h030, 1, 1'b0, 1); finish_wait();
    chk(done && !fail, "R4", "re-read succeeds", {done, fail}, 2);
    chk(reads == 2, "R4", "one confirming read", reads, 2);

    // R6: toggle with bit 5 at completion, budget of one
    knobs(0, 2, 2);
    expect_prog(18'h038, src_arr[0]);
    kick(18'h038, 1, 1'b1, 1); finish_wait();
    chk(done && !fail, "R6", "re-read pair succeeds", {done, fail}, 2);
    chk(reads == 4, "R6", "one confirming pair", reads, 4);

    // R4 R8: persistent timeout on second byte of three
    knobs(1, 1000, 2);
    expect_prog(18'h040, src_arr[0]); expect_prog(18'h041, src_arr[1]);
    exp_q.push_back({18'h041, 8'hF0});
    kick(18'h040, 3, 1'b0, 20); finish_wait();
    chk(fail && !done, "R8", "fail flag", {done, fail}, 1);
    chk(fail_addr == 18'h041, "R8", "fail_addr", fail_addr, 18'h041);
    chk(takes == 2, "R8", "no further bytes", takes, 2);
    chk(reads == 6, "R4", "single extra read before fail", reads, 6);
    chk(exp_q.size() == 0, "R8", "pending writes", exp_q.size(), 0);

    // R11: accepted start clears fail
    knobs(-1, 2, 0);
    expect_prog(18'h050, src_arr[0]);
    kick(18'h050, 1, 1'b0, 20);
    chk(busy && !fail && !done, "R11", "flags cleared on start", {busy, done, fail}, 4);
    finish_wait();
    chk(done, "R11", "done after restart", done, 1);

    // R6 R8: toggle persistent timeout
    knobs(0, 1000, 2);
    expect_prog(18'h058, src_arr[0]); exp_q.push_back({18'h058, 8'hF0});
    kick(18'h058, 1, 1'b1, 20); finish_wait();
    chk(fail && fail_addr == 18'h058, "R6", "toggle timeout fails", {fail, 1'b0}, 2);
    chk(reads == 4, "R6", "one extra pair", reads, 4);

    // R9: budget exhaustion, bit 7 mode
    knobs(0, 1000, 0);
    expect_prog(18'h060, src_arr[0]); exp_q.push_back({18'h060, 8'hF0});
    kick(18'h060, 1, 1'b0, 5); finish_wait();
    chk(fail && reads == 5, "R9", "bit7 budget 5 reads", reads, 5);

    // R9: budget exhaustion, toggle mode
    expect_prog(18'h068, src_arr[0]); exp_q.push_back({18'h068, 8'hF0});
    kick(18'h068, 1, 1'b1, 3); finish_wait();
    chk(fail && reads == 6, "R9", "toggle budget 3 pairs", reads, 6);

    // R9: zero budget acts as one
    expect_prog(18'h070, src_arr[0]); exp_q.push_back({18'h070, 8'hF0});
    kick(18'h070, 1, 1'b0, 0); finish_wait();
    chk(fail && reads == 1, "R9", "zero budget", reads, 1);
    chk(exp_q.size() == 0, "R8", "pending writes", exp_q.size(), 0);

    // R11: zero byte count
    knobs(-1, 2, 0);
    kick(18'h078, 0, 1'b0, 20);
    chk(done && !busy && !fail, "R11", "zero count done", {busy, done, fail}, 2);
    chk(reads == 0 && takes == 0, "R11", "no bus activity", reads + takes, 0);

    // R11: start while busy is ignored
    expect_prog(18'h080, src_arr[0]); expect_prog(18'h081, src_arr[1]);
    kick(18'h080, 2, 1'b0, 20);
    repeat (8) @(negedge clk);
    start_addr = 18'h090; byte_count = 5; start = 1'b1;
    @(negedge clk); start = 1'b0;
    finish_wait();
    chk(done && takes == 2, "R11", "second start ignored", takes, 2);
    chk(exp_q.size() == 0, "R11", "pending writes", exp_q.size(), 0);

    // R3 R10: address of reads and strobe widths
    chk(rd_bad == 0, "R3", "reads at target address", rd_bad, 0);
    chk(wid_bad == 0 && wid_seen > 0, "R10", "strobe width errors", wid_bad, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end

endmodule